// File: doc/BRIEF.md
# Key-Sequence Register Unlock Controller

This block guards two write-protected control domains on a simple register bus. One is a main control domain that holds the program/erase settings. The other is an option domain that sits inside the same control register and covers the option-load launch bit. Both domains come out of reset locked.

Software opens the main domain by writing two fixed 32-bit keys to the main key register, one straight after the other. It opens the option domain in the same way through the option key register, but only once the main domain is open. A wrong key value, a wrong order, an unrelated write between the two keys, or a key write to a domain that is already open is treated as an attack. In each of these cases the domain stays locked until the next reset.

While a domain is locked, the block ignores software writes to the control bits that the domain protects. Software can lock a domain again through the control register, but it can never unlock one that way.

Top module: `keylock_unlock`

## Requirements
- R1: After reset both lock outputs are 1, `optLoadStart` is 0, and the control-register read value is 0xC0000000.
- R2: The main lock clears on the clock edge that captures a write of 0xCDEF89AB to address 0x08, provided the previous bus write was 0x45670123 to address 0x08.
- R3: A first main key other than 0x45670123, or a second main key other than 0xCDEF89AB, leaves the main lock set. Every later key sequence, including the correct one, is then ignored until reset.
- R4: Any bus write to another address that comes between the first and second key of a sequence latches that domain locked until reset.
- R5: The option lock clears when 0x08192A3B and then 0x4C5D6E7F are written to address 0x0C while the main lock is clear.
- R6: Writes to the option key register while the main lock is set have no effect, and a correct option sequence still works once the main lock is clear.
- R7: A key write to a domain that is already open locks that domain until reset.
- R8: While the main lock is set, writes to the control register at 0x14 are ignored. While it is clear, data bits [15:0] are stored and read back in bits [15:0].
- R9: Writing 1 to bit 27 of the control register produces a one-cycle `optLoadStart` pulse in the cycle after the write. This happens only if both locks were clear when the write was made; otherwise the write has no effect on `optLoadStart`.
- R10: Writing 1 to control bit 31 relocks the main domain, and writing 1 to bit 30 relocks the option domain (when the main domain is open). A relocked domain can be reopened with a correct sequence, and writing 0 to these bits never unlocks a domain.
- R11: Reads of either key address return 0. A read of the control register returns the main lock in bit 31, the option lock in bit 30, the stored field in bits [15:0], and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 32 | Combinational read data |
| mainLocked | output | 1 | Main domain lock state |
| optLocked | output | 1 | Option domain lock state |
| optLoadStart | output | 1 | One-cycle option-load launch pulse |

## Verification
A single control-register write can relock the option domain and request an option-load launch in the same cycle. The block must judge the launch against the lock state as it stood before that write. The bench provokes this by writing bit 30 and bit 27 together while both domains are open. It expects the launch pulse in the following cycle and then reads back the option lock as set. A failed-sequence latch and a relock can also coincide when a control write falls between two option keys. The bench checks that the option domain then stays shut even against a correct sequence.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_HALF,
    SEQ_OPEN,
    SEQ_DEAD
  } seqState_t;

  typedef struct packed {
    logic fieldWr;
    logic launchWr;
  } dpStrobe_t;
endpackage

// File: rtl/keylock_seq.sv
module keylock_seq #(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] KEY_FIRST  = 32'h0,
  parameter logic [31:0] KEY_SECOND = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWr,
  input  logic              otherWr,
  input  logic              relock,
  input  logic [DATA_W-1:0] keyData,
  output logic              locked
);
  import keylock_pkg::*;

  localparam logic [DATA_W-1:0] K1 = KEY_FIRST[DATA_W-1:0];
  localparam logic [DATA_W-1:0] K2 = KEY_SECOND[DATA_W-1:0];

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (keyWr) stateNext = (keyData == K1) ? SEQ_HALF : SEQ_DEAD;
      SEQ_HALF: begin
        if (keyWr)        stateNext = (keyData == K2) ? SEQ_OPEN : SEQ_DEAD;
        else if (otherWr) stateNext = SEQ_DEAD;
      end
      SEQ_OPEN: begin
        if (keyWr)       stateNext = SEQ_DEAD;
        else if (relock) stateNext = SEQ_IDLE;
      end
      default: stateNext = SEQ_DEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign locked = (state != SEQ_OPEN);
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl #(
  parameter int          ADDR_W          = 8,
  parameter int          DATA_W          = 32,
  parameter logic [7:0]  MAIN_KEY_ADDR   = 8'h08,
  parameter logic [7:0]  OPT_KEY_ADDR    = 8'h0C,
  parameter logic [7:0]  CTRL_ADDR       = 8'h14,
  parameter logic [31:0] MAIN_KEY1       = 32'h45670123,
  parameter logic [31:0] MAIN_KEY2       = 32'hCDEF89AB,
  parameter logic [31:0] OPT_KEY1        = 32'h08192A3B,
  parameter logic [31:0] OPT_KEY2        = 32'h4C5D6E7F,
  parameter int          MAIN_RELOCK_BIT = 31,
  parameter int          OPT_RELOCK_BIT  = 30,
  parameter int          LAUNCH_BIT      = 27
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic                     mainLocked,
  output logic                     optLocked,
  output keylock_pkg::dpStrobe_t   strobe
);
  localparam logic [ADDR_W-1:0] A_MAIN = MAIN_KEY_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_OPT  = OPT_KEY_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ADDR[ADDR_W-1:0];

  logic hitMain, hitOpt, hitCtrl, mainOpen;

  assign hitMain  = wrEn && (wrAddr == A_MAIN);
  assign hitOpt   = wrEn && (wrAddr == A_OPT);
  assign hitCtrl  = wrEn && (wrAddr == A_CTRL);
  assign mainOpen = !mainLocked;

  keylock_seq #(
    .DATA_W(DATA_W), .KEY_FIRST(MAIN_KEY1), .KEY_SECOND(MAIN_KEY2)
  ) u_mainSeq (
    .clk(clk), .rstN(rstN),
    .keyWr(hitMain),
    .otherWr(wrEn && !hitMain),
    .relock(hitCtrl && mainOpen && wrData[MAIN_RELOCK_BIT]),
    .keyData(wrData),
    .locked(mainLocked)
  );

  keylock_seq #(
    .DATA_W(DATA_W), .KEY_FIRST(OPT_KEY1), .KEY_SECOND(OPT_KEY2)
  ) u_optSeq (
    .clk(clk), .rstN(rstN),
    .keyWr(hitOpt && mainOpen),
    .otherWr(wrEn && !hitOpt),
    .relock(hitCtrl && mainOpen && wrData[OPT_RELOCK_BIT]),
    .keyData(wrData),
    .locked(optLocked)
  );

  always_comb begin
    strobe.fieldWr  = hitCtrl && mainOpen;
    strobe.launchWr = hitCtrl && mainOpen && !optLocked && wrData[LAUNCH_BIT];
  end
endmodule

// File: rtl/keylock_dp.sv
module keylock_dp #(
  parameter int         ADDR_W          = 8,
  parameter int         DATA_W          = 32,
  parameter int         FIELD_W         = 16,
  parameter logic [7:0] CTRL_ADDR       = 8'h14,
  parameter int         MAIN_RELOCK_BIT = 31,
  parameter int         OPT_RELOCK_BIT  = 30
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  keylock_pkg::dpStrobe_t strobe,
  input  logic [FIELD_W-1:0]     fieldIn,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic                   mainLocked,
  input  logic                   optLocked,
  output logic [DATA_W-1:0]      rdData,
  output logic [FIELD_W-1:0]     ctrlField,
  output logic                   optLoadStart
);
  localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ADDR[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlField    <= '0;
      optLoadStart <= 1'b0;
    end else begin
      if (strobe.fieldWr) ctrlField <= fieldIn;
      optLoadStart <= strobe.launchWr;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == A_CTRL) begin
      rdData[MAIN_RELOCK_BIT] = mainLocked;
      rdData[OPT_RELOCK_BIT]  = optLocked;
      rdData[FIELD_W-1:0]     = ctrlField;
    end
  end
endmodule

// File: rtl/keylock_unlock.sv
module keylock_unlock #(
  parameter int          ADDR_W          = 8,
  parameter int          DATA_W          = 32,
  parameter int          FIELD_W         = 16,
  parameter logic [7:0]  MAIN_KEY_ADDR   = 8'h08,
  parameter logic [7:0]  OPT_KEY_ADDR    = 8'h0C,
  parameter logic [7:0]  CTRL_ADDR       = 8'h14,
  parameter logic [31:0] MAIN_KEY1       = 32'h45670123,
  parameter logic [31:0] MAIN_KEY2       = 32'hCDEF89AB,
  parameter logic [31:0] OPT_KEY1        = 32'h08192A3B,
  parameter logic [31:0] OPT_KEY2        = 32'h4C5D6E7F,
  parameter int          MAIN_RELOCK_BIT = 31,
  parameter int          OPT_RELOCK_BIT  = 30,
  parameter int          LAUNCH_BIT      = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              mainLocked,
  output logic              optLocked,
  output logic              optLoadStart
);
  keylock_pkg::dpStrobe_t strobe;
  logic [FIELD_W-1:0]     ctrlField;

  keylock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAIN_KEY_ADDR(MAIN_KEY_ADDR), .OPT_KEY_ADDR(OPT_KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .MAIN_KEY1(MAIN_KEY1), .MAIN_KEY2(MAIN_KEY2), .OPT_KEY1(OPT_KEY1), .OPT_KEY2(OPT_KEY2),
    .MAIN_RELOCK_BIT(MAIN_RELOCK_BIT), .OPT_RELOCK_BIT(OPT_RELOCK_BIT), .LAUNCH_BIT(LAUNCH_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mainLocked(mainLocked), .optLocked(optLocked), .strobe(strobe)
  );

  keylock_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .CTRL_ADDR(CTRL_ADDR),
    .MAIN_RELOCK_BIT(MAIN_RELOCK_BIT), .OPT_RELOCK_BIT(OPT_RELOCK_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fieldIn(wrData[FIELD_W-1:0]),
    .rdAddr(rdAddr), .mainLocked(mainLocked), .optLocked(optLocked),
    .rdData(rdData), .ctrlField(ctrlField), .optLoadStart(optLoadStart)
  );
endmodule

// File: rtl/keylock_unlock_chk.sv
module keylock_unlock_chk #(
  parameter int          ADDR_W        = 8,
  parameter int          DATA_W        = 32,
  parameter int          FIELD_W       = 16,
  parameter logic [7:0]  MAIN_KEY_ADDR = 8'h08,
  parameter logic [7:0]  OPT_KEY_ADDR  = 8'h0C,
  parameter logic [7:0]  CTRL_ADDR     = 8'h14,
  parameter logic [31:0] MAIN_KEY2     = 32'hCDEF89AB,
  parameter logic [31:0] OPT_KEY2      = 32'h4C5D6E7F,
  parameter int          LAUNCH_BIT    = 27
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic               mainLocked,
  input logic               optLocked,
  input logic               optLoadStart,
  input logic [FIELD_W-1:0] ctrlField
);
  localparam logic [ADDR_W-1:0] A_MAIN = MAIN_KEY_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_OPT  = OPT_KEY_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ADDR[ADDR_W-1:0];
  localparam logic [DATA_W-1:0] K2M    = MAIN_KEY2[DATA_W-1:0];
  localparam logic [DATA_W-1:0] K2O    = OPT_KEY2[DATA_W-1:0];

  // R2
  main_open_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainLocked) |-> $past(wrEn && wrAddr == A_MAIN && wrData == K2M));

  // R5
  opt_open_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(optLocked) |-> $past(!mainLocked && wrEn && wrAddr == A_OPT && wrData == K2O));

  // R7
  open_rekey_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mainLocked && wrEn && wrAddr == A_MAIN) |=> mainLocked);

  // R8
  locked_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainLocked && wrEn && wrAddr == A_CTRL) |=> $stable(ctrlField));

  // R9
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    optLoadStart |-> $past(!mainLocked && !optLocked && wrEn && wrAddr == A_CTRL && wrData[LAUNCH_BIT]));
endmodule

bind keylock_unlock keylock_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
  .MAIN_KEY_ADDR(MAIN_KEY_ADDR), .OPT_KEY_ADDR(OPT_KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
  .MAIN_KEY2(MAIN_KEY2), .OPT_KEY2(OPT_KEY2), .LAUNCH_BIT(LAUNCH_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .mainLocked(mainLocked), .optLocked(optLocked), .optLoadStart(optLoadStart),
  .ctrlField(ctrlField)
);

// File: tb/keylock_unlock_tb.sv
module keylock_unlock_tb;
  localparam logic [7:0]  A_MAIN = 8'h08;
  localparam logic [7:0]  A_OPT  = 8'h0C;
  localparam logic [7:0]  A_CTRL = 8'h14;
  localparam logic [31:0] MK1 = 32'h45670123, MK2 = 32'hCDEF89AB;
  localparam logic [31:0] OK1 = 32'h08192A3B, OK2 = 32'h4C5D6E7F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic [31:0] rdData;
  logic mainLocked, optLocked, optLoadStart;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit          isLaunch;
    logic [31:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  keylock_unlock u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .mainLocked(mainLocked),
    .optLocked(optLocked), .optLoadStart(optLoadStart)
  );

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      act = it.isLaunch ? {31'b0, optLoadStart} : rdData;
      checks++;
      if (act !== it.val) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
      end
    end
  end

  function automatic logic [31:0] ctrlVal(bit m, bit o, logic [15:0] f);
    return {m, o, 14'b0, f};
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expectRd(logic [7:0] a, logic [31:0] v, string tag);
    expItem_t it;
    rdAddr = a;
    it.isLaunch = 1'b0; it.val = v; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expectLaunch(bit v, string tag);
    expItem_t it;
    it.isLaunch = 1'b1; it.val = {31'b0, v}; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R1 reset ctrl");
    expectLaunch(0, "R1 reset launch");
    expectRd(A_MAIN, 32'h0, "R11 main key reads zero");

    wr(A_CTRL, 32'h0000_1234);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R8 locked ctrl write ignored");

    wr(A_OPT, OK1); wr(A_OPT, OK2);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R6 opt keys ignored while main locked");

    wr(A_MAIN, MK1); wr(A_MAIN, MK2);
    expectRd(A_CTRL, ctrlVal(0, 1, 16'h0), "R2 main unlock");
    expectRd(A_MAIN, 32'h0, "R11 main key reads zero when open");
    expectRd(A_OPT, 32'h0, "R11 opt key reads zero");

    wr(A_CTRL, 32'h0000_ABCD);
    expectRd(A_CTRL, ctrlVal(0, 1, 16'hABCD), "R8 open ctrl write stored");

    wr(A_CTRL, 32'h0800_ABCD);
    expectLaunch(0, "R9 launch ignored while opt locked");

    wr(A_OPT, OK1); wr(A_OPT, OK2);
    expectRd(A_CTRL, ctrlVal(0, 0, 16'hABCD), "R5 R6 opt unlock");

    wr(A_CTRL, 32'h0800_ABCD);
    expectLaunch(1, "R9 launch pulse");
    expectLaunch(0, "R9 launch single cycle");

    // relock option and launch in the same write
    wr(A_CTRL, 32'h4800_ABCD);
    expectLaunch(1, "R9 launch with simultaneous relock");
    expectRd(A_CTRL, ctrlVal(0, 1, 16'hABCD), "R10 opt relock");

    wr(A_CTRL, 32'h8000_ABCD);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'hABCD), "R10 main relock");
    wr(A_CTRL, 32'h0000_0000);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'hABCD), "R10 zero write no unlock");
    wr(A_MAIN, MK1); wr(A_MAIN, MK2);
    expectRd(A_CTRL, ctrlVal(0, 1, 16'hABCD), "R10 main reopen");

    wr(A_OPT, OK1);
    wr(A_CTRL, 32'h0000_ABCD);
    wr(A_OPT, OK2);
    expectRd(A_CTRL, ctrlVal(0, 1, 16'hABCD), "R4 opt interrupted sequence");
    wr(A_OPT, OK1); wr(A_OPT, OK2);
    expectRd(A_CTRL, ctrlVal(0, 1, 16'hABCD), "R4 opt latched locked");

    wr(A_MAIN, MK1);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'hABCD), "R7 rekey open main locks");
    wr(A_MAIN, MK1); wr(A_MAIN, MK2);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'hABCD), "R7 main stays locked");

    doReset();
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R1 second reset");
    wr(A_MAIN, 32'h1234_5678);
    wr(A_MAIN, MK1); wr(A_MAIN, MK2);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R3 wrong first key latches");

    doReset();
    wr(A_MAIN, MK1); wr(A_MAIN, MK1);
    wr(A_MAIN, MK1); wr(A_MAIN, MK2);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R3 wrong second key latches");

    doReset();
    wr(A_MAIN, MK1);
    wr(8'h00, 32'h0);
    wr(A_MAIN, MK2);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R4 main interrupted sequence");

    doReset();
    wr(A_MAIN, MK2); wr(A_MAIN, MK1);
    expectRd(A_CTRL, ctrlVal(1, 1, 16'h0), "R3 swapped order");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule